// File: doc/BRIEF.md
# Early-Terminating Iterative Multiplier

This block is a sequential 32 by 32 multiplier. It consumes the multiplier operand (`op_b`) one 8-bit slice per cycle. It stops as soon as the slices it has not yet consumed carry no information: all zero bits, or for sign-sensitive forms all copies of the sign bit. As a result, small multipliers finish in one array cycle and full-width ones take four.

One start pulse launches one operation, and the operands are captured on that edge. The control inputs choose among three result forms:
- a 32-bit product, with an optional 32-bit addend;
- a 64-bit signed product;
- a 64-bit unsigned product.

Each 64-bit form may add a 64-bit high:low addend. The accumulate and 64-bit forms each spend a fixed number of extra cycles after the array cycles. `busy` covers the whole operation. `done` pulses on its final cycle, at which point `result` and the N/Z flags are valid. The outputs then hold until the next accepted start.

Top module: `iter_mult`

## Requirements
- R1: With `is_long`=0, `result[31:0]` is the low 32 bits of `op_a`×`op_b` and `result[63:32]` is zero, whatever the value of `is_signed`.
- R2: With `is_long`=0 and `do_acc`=1, `result[31:0]` is (`op_a`×`op_b` + `acc_lo`) modulo 2^32.
- R3: With `is_long`=1, `result` is the 64-bit product, taken as two's complement when `is_signed`=1 and as unsigned otherwise. With `do_acc`=1, {`acc_hi`,`acc_lo`} is added to it modulo 2^64.
- R4: For the 32-bit forms and the signed 64-bit forms, the array count m is:
  - 1 when `op_b` bits [31:8] are all equal to bit 31 (`op_b` in −256..255 as a signed value);
  - 2 when bits [31:16] are all equal to bit 31;
  - 3 when bits [31:24] are all equal to bit 31;
  - 4 otherwise.
- R5: For the unsigned 64-bit forms, m is 1, 2 or 3 only when `op_b` bits [31:8], [31:16] or [31:24] respectively are all zero; otherwise m is 4.
- R6: The operation occupies m cycles for a 32-bit multiply, m+1 for a 32-bit multiply-accumulate, m+1 for a 64-bit multiply and m+2 for a 64-bit multiply-accumulate. These cycles are counted from the cycle after the start edge through the `done` cycle.
- R7: In the 32-bit forms at `done`, `flag_n` equals `result[31]` and `flag_z` is 1 exactly when `result[31:0]` is zero.
- R8: In the 64-bit forms at `done`, `flag_n` equals `result[63]` and `flag_z` is 1 exactly when all 64 result bits are zero.
- R9: `busy` is high from the cycle after an accepted start through the `done` cycle and low in the cycle after it. `done` is high for exactly one cycle per operation.
- R10: A start pulse while `busy` is high, including in the `done` cycle, is ignored: the running result is unchanged and no new operation begins.
- R11: After reset, `busy`=0, `done`=0 and `result`=0.
- R12: While idle with no start, `result` and the flags hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier, consumed 8 bits per cycle |
| acc_hi | input | 32 | High word of the 64-bit addend |
| acc_lo | input | 32 | 32-bit addend, or low word of the 64-bit addend |
| is_signed | input | 1 | 64-bit forms: two's complement operands |
| is_long | input | 1 | Select the 64-bit result form |
| do_acc | input | 1 | Add the accumulator inputs |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on the final cycle |
| result | output | 64 | Product or product plus addend |
| flag_n | output | 1 | Negative flag of the result |
| flag_z | output | 1 | Zero flag of the result |

## Verification
The sweep places `op_b` on each side of every band edge, both positive and negative: 0xFF against 0x100, 0xFFFFFF00 against 0xFFFFFEFF, and 0x80000000. It runs every one of these values through all six result forms.
- A design that folded the sign in the unsigned 64-bit forms would finish those forms too early and produce a wrong high word.
- A design that treated the top slice as plain 8-bit signed would get values such as −129 wrong.

The accumulate cases use addends that carry out of the low word, which exposes a lost carry between the two halves. Start pulses injected mid-run and in the `done` cycle expose a design that relaunches or overwrites its captured operands.

// File: rtl/iter_mult_pkg.sv
package iter_mult_pkg;
    parameter int DW = 32;                 // operand width
    parameter int CW = 8;                  // multiplier bits retired per cycle
    localparam int NCH = DW / CW;          // slices in the multiplier
    localparam int IW  = $clog2(NCH);      // slice index width
    localparam int PW  = 2 * DW;           // product width

    typedef enum logic [2:0] {
        PH_IDLE, PH_ARRAY, PH_ACC_LO, PH_ACC_HI, PH_HOLD, PH_DONE
    } phase_e;

    typedef struct packed {
        logic sgn_band;   // sign-folded banding and signed top slice
        logic is_long;
        logic do_acc;
    } mode_t;

    function automatic phase_e after_array(input mode_t md);
        if (md.do_acc)       return PH_ACC_LO;
        else if (md.is_long) return PH_HOLD;
        else                 return PH_DONE;
    endfunction

    function automatic phase_e after_acc_lo(input mode_t md);
        return md.is_long ? PH_ACC_HI : PH_DONE;
    endfunction
endpackage

// File: rtl/iter_mult_band.sv
module iter_mult_band
    import iter_mult_pkg::*;
(
    input  logic [DW-1:0] mplier,
    input  logic          sgn_band,
    output logic [IW-1:0] last_idx
);
    logic [DW-1:0] folded;

    // Signed forms fold negative values so that a run of ones above a
    // slice boundary ends the array just like a run of zeros.
    always_comb begin
        folded   = (sgn_band && mplier[DW-1]) ? ~mplier : mplier;
        last_idx = IW'(NCH - 1);
        for (int k = NCH - 1; k >= 1; k--) begin
            if ((folded >> (k * CW)) == '0)
                last_idx = IW'(k - 1);
        end
    end
endmodule

// File: rtl/iter_mult_pp.sv
module iter_mult_pp
    import iter_mult_pkg::*;
(
    input  logic [PW-1:0] mcand,
    input  logic [CW-1:0] chunk,
    input  logic          neg,
    input  logic [IW-1:0] idx,
    output logic [PW-1:0] pp
);
    logic [PW-1:0] cext;

    // The top slice of a negative signed multiplier is worth
    // chunk - 2^CW, since every bit above it is a one.
    always_comb begin
        cext = {{(PW-CW){neg}}, chunk};
        pp   = (mcand * cext) << (int'(idx) * CW);
    end
endmodule

// File: rtl/iter_mult.sv
module iter_mult
    import iter_mult_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [31:0]   op_a,
    input  logic [31:0]   op_b,
    input  logic [31:0]   acc_hi,
    input  logic [31:0]   acc_lo,
    input  logic          is_signed,
    input  logic          is_long,
    input  logic          do_acc,
    output logic          busy,
    output logic          done,
    output logic [63:0]   result,
    output logic          flag_n,
    output logic          flag_z
);
    phase_e        phase_q;
    mode_t         mode_q, mode_in;
    logic [PW-1:0] mcand_q, acc_q, prod_q;
    logic [DW-1:0] mplier_q;
    logic [IW-1:0] idx_q, last_q;
    logic          cy_q;

    logic          take;
    logic [IW-1:0] band_last;
    logic [PW-1:0] mcand_in, arr_mcand, pp;
    logic [DW-1:0] arr_mplier;
    logic [IW-1:0] arr_idx, arr_last;
    logic          arr_sgn, arr_neg;
    logic [CW-1:0] arr_chunk;
    logic [DW:0]   lo_sum;

    assign take = start && (phase_q == PH_IDLE);

    always_comb begin
        mode_in.sgn_band = is_signed || !is_long;
        mode_in.is_long  = is_long;
        mode_in.do_acc   = do_acc;
        mcand_in = mode_in.sgn_band ? {{DW{op_a[DW-1]}}, op_a} : {{DW{1'b0}}, op_a};
    end

    iter_mult_band u_band (
        .mplier   (op_b),
        .sgn_band (mode_in.sgn_band),
        .last_idx (band_last)
    );

    // The start edge already runs slice 0 from the port values.
    always_comb begin
        arr_mcand  = take ? mcand_in         : mcand_q;
        arr_mplier = take ? op_b             : mplier_q;
        arr_idx    = take ? '0               : idx_q;
        arr_last   = take ? band_last        : last_q;
        arr_sgn    = take ? mode_in.sgn_band : mode_q.sgn_band;
        arr_chunk  = CW'(arr_mplier >> (int'(arr_idx) * CW));
        arr_neg    = arr_sgn && arr_mplier[DW-1] && (arr_idx == arr_last);
        lo_sum     = {1'b0, prod_q[DW-1:0]} + {1'b0, acc_q[DW-1:0]};
    end

    iter_mult_pp u_pp (
        .mcand (arr_mcand),
        .chunk (arr_chunk),
        .neg   (arr_neg),
        .idx   (arr_idx),
        .pp    (pp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            mode_q   <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
            prod_q   <= '0;
            idx_q    <= '0;
            last_q   <= '0;
            cy_q     <= 1'b0;
        end else if (take) begin
            mode_q   <= mode_in;
            mcand_q  <= mcand_in;
            mplier_q <= op_b;
            acc_q    <= {acc_hi, acc_lo};
            last_q   <= band_last;
            prod_q   <= pp;
            cy_q     <= 1'b0;
            idx_q    <= IW'(1);
            phase_q  <= (band_last == '0) ? after_array(mode_in) : PH_ARRAY;
        end else begin
            unique case (phase_q)
                PH_ARRAY: begin
                    prod_q <= prod_q + pp;
                    if (idx_q == last_q) phase_q <= after_array(mode_q);
                    else                 idx_q   <= idx_q + IW'(1);
                end
                PH_ACC_LO: begin
                    prod_q[DW-1:0] <= lo_sum[DW-1:0];
                    cy_q           <= lo_sum[DW];
                    phase_q        <= after_acc_lo(mode_q);
                end
                PH_ACC_HI: begin
                    prod_q[PW-1:DW] <= prod_q[PW-1:DW] + acc_q[PW-1:DW] + {{(DW-1){1'b0}}, cy_q};
                    phase_q         <= PH_DONE;
                end
                PH_HOLD: phase_q <= PH_DONE;
                PH_DONE: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        busy   = (phase_q != PH_IDLE);
        done   = (phase_q == PH_DONE);
        result = mode_q.is_long ? prod_q : {{DW{1'b0}}, prod_q[DW-1:0]};
        flag_n = mode_q.is_long ? prod_q[PW-1] : prod_q[DW-1];
        flag_z = mode_q.is_long ? (prod_q == '0) : (prod_q[DW-1:0] == '0);
    end

    // Cycle counter used only by the length check below.
    localparam int MAX_LEN = NCH + 2;
    logic [3:0] busy_cnt;
    always_ff @(posedge clk) begin
        if (rst || !busy) busy_cnt <= '0;
        else              busy_cnt <= busy_cnt + 4'd1;
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R9
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst) done |=> !busy);
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst) (busy && !done) |=> busy);
    // R10
    op_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> ($stable(mplier_q) && $stable(mcand_q) && $stable(mode_q)));
    // R6
    len_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(busy_cnt) < MAX_LEN));
    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result));
endmodule

// File: tb/iter_mult_tb.sv
module iter_mult_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] op_a, op_b, acc_hi, acc_lo;
    logic        is_signed, is_long, do_acc;
    logic        busy, done, flag_n, flag_z;
    logic [63:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    iter_mult u_dut (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .is_signed(is_signed),
        .is_long(is_long), .do_acc(do_acc), .busy(busy), .done(done),
        .result(result), .flag_n(flag_n), .flag_z(flag_z)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int band_m(input logic [31:0] b, input bit sgn);
        longint v;
        if (sgn) begin
            v = longint'($signed(b));
            if (v >= -256 && v < 256) return 1;
            if (v >= -65536 && v < 65536) return 2;
            if (v >= -(64'sd1 << 24) && v < (64'sd1 << 24)) return 3;
            return 4;
        end
        v = longint'(b);
        if (v < 256) return 1;
        if (v < 65536) return 2;
        if (v < (64'sd1 << 24)) return 3;
        return 4;
    endfunction

    // mode: 0 short mul, 1 short acc, 2 long u, 3 long s, 4 long u acc, 5 long s acc
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [31:0] ah,
                          input logic [31:0] al, input int mode, input bit poke);
        bit lng, sgn, acc, all_busy;
        int cyc, exp_cyc, m;
        logic [63:0] ea, eb, exp_r, held;
        lng = (mode >= 2);
        sgn = (mode == 3) || (mode == 5);
        acc = (mode == 1) || (mode >= 4);
        @(negedge clk);
        op_a = a; op_b = b; acc_hi = ah; acc_lo = al;
        is_long = lng; do_acc = acc;
        is_signed = lng ? sgn : a[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1; all_busy = 1;
        while (!done && cyc < 20) begin
            if (!busy) all_busy = 0;
            if (poke) begin
                start = 1'b1; op_a = ~a; op_b = b ^ 32'h5A5A_0F0F; acc_lo = ~al;
            end
            @(negedge clk);
            cyc++;
        end
        if (!busy) all_busy = 0;
        if (poke) begin start = 1'b1; op_a = 32'h1234_5678; end
        // expected values
        m = band_m(b, lng ? sgn : 1'b1);
        exp_cyc = m + (acc ? 1 : 0) + (lng ? 1 : 0);
        ea = (lng && sgn) ? {{32{a[31]}}, a} : {32'b0, a};
        eb = (lng && sgn) ? {{32{b[31]}}, b} : {32'b0, b};
        exp_r = ea * eb;
        if (lng) begin
            if (acc) exp_r = exp_r + {ah, al};
        end else begin
            exp_r = {32'b0, exp_r[31:0] + (acc ? al : 32'b0)};
        end
        check(cyc == exp_cyc, lng ? (sgn ? "R6/R4 cycles" : "R6/R5 cycles") : "R6/R4 cycles",
              64'(cyc), 64'(exp_cyc));
        check(all_busy, "R9 busy through run", 64'(all_busy), 64'd1);
        check(result == exp_r, lng ? "R3 result" : (acc ? "R2 result" : "R1 result"), result, exp_r);
        if (lng) begin
            check(flag_n == exp_r[63] && flag_z == (exp_r == 64'd0), "R8 flags",
                  {62'b0, flag_n, flag_z}, {62'b0, exp_r[63], exp_r == 64'd0});
        end else begin
            check(flag_n == exp_r[31] && flag_z == (exp_r[31:0] == 32'd0), "R7 flags",
                  {62'b0, flag_n, flag_z}, {62'b0, exp_r[31], exp_r[31:0] == 32'd0});
        end
        held = result;
        @(negedge clk);
        start = 1'b0;
        check(!done && !busy, poke ? "R10 no relaunch" : "R9 end of run",
              {62'b0, busy, done}, 64'd0);
        @(negedge clk);
        check(result == held && !busy, poke ? "R10 result kept" : "R12 idle hold", result, held);
    endtask

    logic [31:0] a_set [5] = '{32'h0000_0000, 32'h0000_0007, 32'hFFFF_FFFF, 32'h8000_0001, 32'h1357_9BDF};
    logic [31:0] b_set [16] = '{32'h0000_0000, 32'h0000_00FF, 32'h0000_0100, 32'h0000_FFFF,
                               32'h0001_0000, 32'h00FF_FFFF, 32'h0100_0000, 32'h7FFF_FFFF,
                               32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FF00, 32'hFFFF_FEFF,
                               32'hFFFF_FF7F, 32'hFFFF_0000, 32'hFF00_0000, 32'hFEFF_FFFF};

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; op_a = '0; op_b = '0; acc_hi = '0; acc_lo = '0;
        is_signed = 1'b0; is_long = 1'b0; do_acc = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(!busy && !done && result == 64'd0, "R11 reset", {result[61:0], busy, done}, 64'd0);
        for (int ai = 0; ai < 5; ai++)
            for (int bi = 0; bi < 16; bi++)
                for (int md = 0; md < 6; md++)
                    run_op(a_set[ai], b_set[bi], 32'hFFFF_FFF0 ^ 32'(bi), 32'hF000_0000 | 32'(ai), md, 1'b0);
        // R10 start pulses while busy and in the done cycle
        run_op(32'hDEAD_BEEF, 32'h8765_4321, 32'h0000_0001, 32'hFFFF_FFFF, 5, 1'b1);
        run_op(32'h0000_0003, 32'h0000_0005, 32'h0, 32'h0000_0010, 1, 1'b1);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 2, 1'b1);
        // R7/R8 zero-flag cases with cancelling accumulate
        run_op(32'h0000_0002, 32'h0000_0003, 32'hFFFF_FFFF, 32'hFFFF_FFFA, 4, 1'b0);
        run_op(32'h0000_0002, 32'h0000_0003, 32'h0, 32'hFFFF_FFFA, 1, 1'b0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule